// File: doc/BRIEF.md
# Cell-array binary to BCD converter

This block turns an unsigned binary word into packed decimal digits with no clock and no state. The output follows the input after a purely combinational delay, so it can sit between any two register stages or drive a display path directly.

The array is built from one small cell type. Each cell takes a 6-bit value from 0 to 63 and returns its two-digit decimal form. The most significant 6 input bits feed a head cell. Each following row then brings in two more input bits. In a row, each digit position takes its previous digit value and appends the two bits that come in from below, which form a 6-bit value. The position then splits that value into a new digit and a 2-bit carry for the digit above. In this way, the add-3 corrections of the double-dabble method for two bit steps are resolved in one cell lookup, and not by iterating over clock cycles.

A digit position whose value is known at elaboration time to stay below 2 cannot overflow when two bits are shifted in. Those positions are plain wires and take no cell. Inputs a cell does not use are tied to zero, and cell outputs that are not used stay on named nets.

Top module: `bin2bcd_array`

## Requirements
- R1: For every 16-bit input value v, bcd_o holds the decimal digits of v, with nibble k (bits 4k+3..4k) equal to the k-th decimal digit counted from the units (nibble 0 is units, nibble 4 is ten-thousands).
- R2: Every 4-bit nibble of bcd_o is in the range 0 to 9 for every input. Codes 10 to 15 never appear.
- R3: The ten-thousands nibble never exceeds 6, and input 65535 gives bcd_o = 0x65535.
- R4: Input 0 gives bcd_o = 0x00000.
- R5: The output depends only on the present input. A new input value is reflected at bcd_o within the same clock period, without any clock edge.
- R6: Bit 0 of bcd_o always equals bit 0 of bin_i.
- R7: Carries across decimal boundaries are correct: 9, 10, 99, 100, 999, 1000, 9999 and 10000 give their exact decimal codes.
- R8: The conversion cell maps every 6-bit value v (0 to 63) to a units digit v mod 10 (ones output, 4 bits) and a tens digit v div 10 (tens output, 3 bits).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bin_i | input | 16 | Unsigned binary value to convert |
| bcd_o | output | 20 | Five packed BCD digits, units in bits 3..0 |

## Verification
The bench looks hardest at the input values just below and at each power of ten. A carry that is lost or misrouted between digit positions would show up there as a wrong digit or as a code above 9. It also drives the maximum input. An array that prunes one cell too many would drop the top carry at that value and return a wrong ten-thousands digit. The cell is swept over all 64 of its values, because a single bad entry would corrupt only a scattered subset of words. An exhaustive pass over all 16-bit words then catches any remaining slip in the row wiring or in the two bits each row takes in.

// File: rtl/bin2bcd_pkg.sv
package bin2bcd_pkg;
  localparam int unsigned CELL_W = 6;
  localparam int unsigned STEP_W = 2;
  localparam int unsigned DIG_W  = 4;

  function automatic longint unsigned pow10(input int unsigned k);
    longint unsigned r = 1;
    for (int unsigned i = 0; i < k; i++) r = r * 10;
    return r;
  endfunction

  // decimal digits needed for an unsigned word of width w
  function automatic int unsigned num_digits(input int unsigned w);
    longint unsigned m = (64'd1 << w) - 1;
    int unsigned n = 1;
    for (int i = 0; i < 20; i++) begin
      if (m >= 10) begin
        m = m / 10;
        n++;
      end
    end
    return n;
  endfunction

  // largest value digit j can take for any word of width bits
  function automatic int unsigned digit_max(input int unsigned bits, input int unsigned j);
    longint unsigned m = (64'd1 << bits) - 1;
    if (m >= pow10(j + 1)) return 9;
    return int'(m / pow10(j));
  endfunction

  // position overflows a decimal digit once STEP_W bits are shifted in
  function automatic bit needs_cell(input int unsigned bits, input int unsigned j);
    return ((digit_max(bits, j) << STEP_W) + ((1 << STEP_W) - 1)) >= 10;
  endfunction
endpackage

// File: rtl/bcd6_cell.sv
module bcd6_cell (
  input  logic [5:0] val_i,
  output logic [3:0] ones_o,
  output logic [2:0] tens_o
);
  logic [4:0] half_rem;

  always_comb begin
    tens_o = 3'd0;
    for (int t = 1; t <= 6; t++) begin
      if (val_i >= 6'(10 * t)) tens_o = 3'(t);
    end
    // bit 0 is untouched by removing multiples of ten
    half_rem    = val_i[5:1] - {tens_o, 2'b00} - {2'b00, tens_o};
    ones_o[0]   = val_i[0];
    ones_o[3:1] = half_rem[2:0];
  end

  always_comb begin
    AST_CELL_ONES: assert (ones_o <= 4'd9) else $error("cell ones out of range"); // R8
    AST_CELL_REM: assert (half_rem[4:3] == 2'b00) else $error("cell remainder wide"); // R8
    AST_CELL_TENS: assert (tens_o <= 3'd6) else $error("cell tens out of range"); // R8
  end
endmodule

// File: rtl/bcd_stage.sv
module bcd_stage #(
  parameter int unsigned DIG_N = 5,
  parameter int unsigned PRE_W = 6
) (
  input  logic [4*DIG_N-1:0] dig_i,
  input  logic [1:0]         bits_i,
  output logic [4*DIG_N-1:0] dig_o,
  output logic [1:0]         carry_o
);
  logic [2*(DIG_N+1)-1:0] cy;

  assign cy[1:0] = bits_i;

  for (genvar j = 0; j < DIG_N; j++) begin : g_pos
    if (bin2bcd_pkg::needs_cell(PRE_W, j)) begin : g_cell
      logic [3:0] ones;
      logic [2:0] tens;
      bcd6_cell u_cell (
        .val_i  ({dig_i[4*j +: 4], cy[2*j +: 2]}),
        .ones_o (ones),
        .tens_o (tens)
      );
      assign dig_o[4*j +: 4]     = ones;
      assign cy[2*(j+1) +: 2]    = tens[1:0];
      always_comb begin
        AST_TENS_FITS: assert (tens[2] == 1'b0) else $error("row carry exceeds 3"); // R1
      end
    end else begin : g_wire
      assign dig_o[4*j +: 4]     = {dig_i[4*j +: 2], cy[2*j +: 2]};
      assign cy[2*(j+1) +: 2]    = 2'b00;
      always_comb begin
        AST_WIRE_SMALL: assert (dig_i[4*j+2 +: 2] == 2'b00) else $error("pruned digit too large"); // R1
      end
    end
  end

  assign carry_o = cy[2*DIG_N +: 2];
endmodule

// File: rtl/bin2bcd_array.sv
module bin2bcd_array #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0]                                    bin_i,
  output logic [4*bin2bcd_pkg::num_digits(DATA_W)-1:0]         bcd_o
);
  import bin2bcd_pkg::*;

  localparam int unsigned DIG_N = num_digits(DATA_W);
  localparam int unsigned ROW_W = DIG_W * DIG_N;
  localparam int unsigned NSTG  = (DATA_W - CELL_W) / STEP_W;
  localparam int unsigned TOP_MAX = digit_max(DATA_W, DIG_N - 1);

  logic [ROW_W-1:0] row [0:NSTG];
  logic [1:0]       stage_cy [0:NSTG];
  logic [3:0]       head_ones;
  logic [2:0]       head_tens;

  bcd6_cell u_head (
    .val_i  (bin_i[DATA_W-1 -: CELL_W]),
    .ones_o (head_ones),
    .tens_o (head_tens)
  );

  assign row[0]      = ROW_W'({head_tens, head_ones});
  assign stage_cy[0] = 2'b00;

  for (genvar s = 1; s <= NSTG; s++) begin : g_row
    bcd_stage #(
      .DIG_N (DIG_N),
      .PRE_W (CELL_W + STEP_W * (s - 1))
    ) u_stage (
      .dig_i   (row[s-1]),
      .bits_i  (bin_i[DATA_W-CELL_W-STEP_W*s +: STEP_W]),
      .dig_o   (row[s]),
      .carry_o (stage_cy[s])
    );
  end

  assign bcd_o = row[NSTG];

  always_comb begin
    for (int k = 0; k < DIG_N; k++) begin
      AST_DIGIT_VALID: assert (bcd_o[4*k +: 4] <= 4'd9) else $error("nibble above 9"); // R2
    end
    for (int s = 0; s <= NSTG; s++) begin
      AST_NO_OVERFLOW: assert (stage_cy[s] == 2'b00) else $error("carry lost off top"); // R1
    end
    AST_TOP_DIGIT: assert (bcd_o[ROW_W-1 -: 4] <= 4'(TOP_MAX)) else $error("top digit too big"); // R3
    AST_LSB_PASS: assert (bcd_o[0] == bin_i[0]) else $error("units lsb differs"); // R6
  end
endmodule

// File: tb/test_bin2bcd_array.sv
`timescale 1ns/100ps
module test_bin2bcd_array;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] bin;
  logic [19:0] bcd;
  logic [5:0]  cell_val;
  logic [3:0]  cell_ones;
  logic [2:0]  cell_tens;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  bin2bcd_array #(.DATA_W(16)) i_bin2bcd_array (.bin_i(bin), .bcd_o(bcd));
  bcd6_cell i_cell (.val_i(cell_val), .ones_o(cell_ones), .tens_o(cell_tens));

  // {input, expected packed decimal}
  localparam logic [35:0] VEC_TAB [0:13] = '{
    {16'd0,     20'h00000}, {16'd1,     20'h00001},
    {16'd9,     20'h00009}, {16'd10,    20'h00010},
    {16'd99,    20'h00099}, {16'd100,   20'h00100},
    {16'd999,   20'h00999}, {16'd1000,  20'h01000},
    {16'd9999,  20'h09999}, {16'd10000, 20'h10000},
    {16'd12345, 20'h12345}, {16'd32768, 20'h32768},
    {16'd59999, 20'h59999}, {16'd65535, 20'h65535}
  };

  function automatic logic [19:0] ref_bcd(input int v);
    logic [19:0] r;
    for (int k = 0; k < 5; k++) begin
      r[4*k +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1: actual hung expected done");
    summary();
  end

  initial begin
    bin = 16'd0;
    cell_val = 6'd0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // R4: zero input after reset
    @(negedge clk);
    check("R4 zero", bcd, 20'h00000);

    // R5: new value visible with no clock edge in between
    @(negedge clk);
    bin = 16'd42;
    #1;
    check("R5 comb", bcd, 20'h00042);

    // R7 R3 R4: table of boundary vectors
    for (int i = 0; i < 14; i++) begin
      @(posedge clk);
      bin = VEC_TAB[i][35:20];
      @(negedge clk);
      check("R7 table", bcd, VEC_TAB[i][19:0]);
    end

    // R3: maximum input and its top digit
    @(posedge clk);
    bin = 16'hFFFF;
    @(negedge clk);
    check("R3 max", bcd, 20'h65535);
    check("R3 top digit", {16'd0, bcd[19:16]}, 20'h00006);

    // R8: every cell input
    for (int v = 0; v < 64; v++) begin
      cell_val = 6'(v);
      #1;
      check("R8 cell", {13'd0, cell_tens, cell_ones}, {13'd0, 3'(v / 10), 4'(v % 10)});
    end

    // R1 R2 R6: exhaustive sweep
    for (int v = 0; v < 65536; v++) begin
      @(posedge clk);
      bin = 16'(v);
      @(negedge clk);
      check("R1 value", bcd, ref_bcd(v));
      begin
        logic bad;
        bad = 1'b0;
        for (int k = 0; k < 5; k++) if (bcd[4*k +: 4] > 4'd9) bad = 1'b1;
        check("R2 nibble range", {19'd0, bad}, 20'd0);
      end
      check("R6 lsb", {19'd0, bcd[0]}, {19'd0, bin[0]});
    end

    summary();
  end
endmodule